// File: doc/BRIEF.md
# Two-Level Virtual Channel Injection Arbiter

This block decides which virtual channel may place a flit on the single local injection port of a router. Four virtual channels compete for that port. One of them, the response channel, is shared by two injectors: one working for the cache controller and one working for the directory controller. A small two-input round-robin arbiter settles which of those two owns the response channel. It keeps that owner until the owner has no packet left pending, so the flits of one packet never interleave with the other injector's flits.

At the port level, a round-robin arbiter looks at every channel that has a packet pending and is not stopped by the router. It advances its priority on every cycle that it grants. The one-hot port grant becomes a binary index. That index steers the chosen channel's flit and flit-valid signal into a register that drives the router. The port output therefore follows the arbitration inputs by one clock.

Top module: `vc_inject_arb`

## Requirements
- R1: A channel takes part in port arbitration only when its pending input is high and its router stop input is low. For the response channel, the pending input is the response channel's own pending term.
- R2: The port arbiter is round-robin. After channel k is granted, the search for the next grant starts at channel k+1 and wraps after the highest channel. Right after reset, channel 0 has the highest priority.
- R3: The port grant, read as an index with bit 0 as channel 0, selects that channel's flit and flit-valid signal. Both are registered and appear on `port_flit` and `port_flit_valid` one clock after the inputs that produced the grant.
- R4: On the response channel, a requester that holds the grant keeps it while its pending input stays high, even if the other requester is also pending.
- R5: When the holder's pending input drops, the response grant rotates to the other requester if that requester is pending. Right after reset, the directory side has priority.
- R6: Response grant bit 0 belongs to the directory side and selects `dir_flit` and `dir_flit_valid`. Bit 1 belongs to the cache side and selects `cache_flit` and `cache_flit_valid`.
- R7: The response channel counts as pending whenever either bit of the response grant is set.
- R8: When no channel is eligible, `port_flit_valid` is low and `port_flit` is all zeros on the next clock.
- R9: While `rst` is high, `port_flit_valid` is low and `port_flit` is zero.
- R10: A granted channel whose flit-valid input is low produces `port_flit_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_pending | input | NUM_VC | Packet pending per channel; bit RESP_VC is unused |
| vc_stop | input | NUM_VC | Router stop per channel |
| vc_flit | input | NUM_VC*FLIT_W | Flit per channel, channel i in bits [i*FLIT_W +: FLIT_W]; slot RESP_VC is unused |
| vc_flit_valid | input | NUM_VC | Flit valid per channel; bit RESP_VC is unused |
| cache_pending | input | 1 | Cache-side response injector has a packet pending |
| cache_flit | input | FLIT_W | Cache-side response flit |
| cache_flit_valid | input | 1 | Cache-side response flit valid |
| dir_pending | input | 1 | Directory-side response injector has a packet pending |
| dir_flit | input | FLIT_W | Directory-side response flit |
| dir_flit_valid | input | 1 | Directory-side response flit valid |
| port_flit | output | FLIT_W | Registered flit toward the router |
| port_flit_valid | output | 1 | Registered flit valid toward the router |

## Verification
The bench first holds three ordinary channels pending together, so the rotation order 0, 2, 3, 0 separates true round-robin from fixed priority. It then stops one of the pending channels to show that a stopped channel is skipped. Next it raises both response requesters at once and drops them one at a time: holding of the grant shows up as the same injector winning twice in a row, and rotation on release shows up as the other injector's flit appearing. Mixing the response channel with channel 0 shows the two levels working together. Idle patterns, a granted channel with a low flit-valid input, and reset expose the zero-output cases.

// File: rtl/vcarb_pkg.sv
package vcarb_pkg;
  // Round-robin pick: first requester after position 'last', wrapping around.
  function automatic int unsigned rr_pick(input logic [31:0] req, input int unsigned last,
                                          input int unsigned n);
    int unsigned idx;
    rr_pick = n;
    for (int unsigned k = 1; k <= n; k++) begin
      idx = (last + k) % n;
      if (rr_pick == n && req[idx]) rr_pick = idx;
    end
  endfunction
endpackage

// File: rtl/onehot_to_index.sv
module onehot_to_index #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  one_hot,
  output logic [IW-1:0] index
);
  always_comb begin
    index = '0;
    for (int i = 0; i < N; i++)
      if (one_hot[i]) index = index | IW'(i);
  end
endmodule

// File: rtl/rr_port_arb.sv
module rr_port_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  import vcarb_pkg::*;
  logic [IW-1:0] last_q;
  int unsigned   pick;

  always_comb begin
    pick  = rr_pick(32'(req), int'(last_q), N);
    grant = '0;
    if (pick < N) grant[pick] = 1'b1;
  end

  // Priority state moves on every granting cycle.
  always_ff @(posedge clk) begin
    if (rst)           last_q <= IW'(N - 1);
    else if (pick < N) last_q <= IW'(pick);
  end

  assert_port_onehot_R2: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  assert_port_grant_req_R1: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  assert_port_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|grant));
endmodule

// File: rtl/hold_rr_arb.sv
module hold_rr_arb #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] hold,
  output logic [N-1:0] grant
);
  import vcarb_pkg::*;
  logic [N-1:0]  gnt_q;
  logic [IW-1:0] last_q;
  int unsigned   pick;

  always_comb begin
    pick  = rr_pick(32'(req), int'(last_q), N);
    grant = '0;
    if (|(gnt_q & hold)) grant = gnt_q;
    else if (pick < N)   grant[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      last_q <= IW'(N - 1);
    end else begin
      gnt_q <= grant;
      for (int i = 0; i < N; i++)
        if (grant[i]) last_q <= IW'(i);
    end
  end

  assert_hold_onehot_R4: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|($past(grant) & hold))) |-> grant == $past(grant));
  assert_hold_release_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (|$past(grant)) && !(|($past(grant) & hold)) && (|(req & ~$past(grant))))
    |-> (grant & $past(grant)) == '0);
endmodule

// File: rtl/vc_inject_arb.sv
module vc_inject_arb #(
  parameter int NUM_VC  = 4,
  parameter int FLIT_W  = 16,
  parameter int RESP_VC = 1,
  localparam int IW = $clog2(NUM_VC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_VC-1:0]        vc_pending,
  input  logic [NUM_VC-1:0]        vc_stop,
  input  logic [NUM_VC*FLIT_W-1:0] vc_flit,
  input  logic [NUM_VC-1:0]        vc_flit_valid,
  input  logic                     cache_pending,
  input  logic [FLIT_W-1:0]        cache_flit,
  input  logic                     cache_flit_valid,
  input  logic                     dir_pending,
  input  logic [FLIT_W-1:0]        dir_flit,
  input  logic                     dir_flit_valid,
  output logic [FLIT_W-1:0]        port_flit,
  output logic                     port_flit_valid
);
  logic [1:0]        resp_req, resp_gnt;
  logic [NUM_VC-1:0] ch_pending, ch_valid, port_req, port_gnt;
  logic [FLIT_W-1:0] ch_flit [NUM_VC];
  logic [IW-1:0]     port_idx;

  // Response sub-arbitration: bit 0 directory side, bit 1 cache side.
  assign resp_req = {cache_pending, dir_pending};

  hold_rr_arb #(.N(2)) resp_arb_i (
    .clk(clk), .rst(rst), .req(resp_req), .hold(resp_req), .grant(resp_gnt));

  for (genvar g = 0; g < NUM_VC; g++) begin : g_ch
    if (g == RESP_VC) begin : g_resp
      assign ch_pending[g] = |resp_gnt;
      assign ch_flit[g]    = resp_gnt[0] ? dir_flit : cache_flit;
      assign ch_valid[g]   = resp_gnt[0] ? dir_flit_valid : cache_flit_valid;
    end else begin : g_plain
      assign ch_pending[g] = vc_pending[g];
      assign ch_flit[g]    = vc_flit[g*FLIT_W +: FLIT_W];
      assign ch_valid[g]   = vc_flit_valid[g];
    end
    assign port_req[g] = ch_pending[g] & ~vc_stop[g];
  end

  rr_port_arb #(.N(NUM_VC)) port_arb_i (
    .clk(clk), .rst(rst), .req(port_req), .grant(port_gnt));

  onehot_to_index #(.N(NUM_VC)) idx_i (.one_hot(port_gnt), .index(port_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      port_flit       <= '0;
      port_flit_valid <= 1'b0;
    end else begin
      port_flit       <= (|port_gnt) ? ch_flit[port_idx] : '0;
      port_flit_valid <= (|port_gnt) & ch_valid[port_idx];
    end
  end

  assert_resp_pending_R7: assert property (@(posedge clk) disable iff (rst)
    ch_pending[RESP_VC] == (resp_req != 2'b00));
  assert_valid_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    port_flit_valid |-> $past(|port_req));
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(|port_req)) |-> (port_flit == '0 && !port_flit_valid));
endmodule

// File: tb/vc_inject_arb_tb.sv
module vc_inject_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int FW = 16;
  localparam int NVEC = 15;
  // {pending[3:0], stop[3:0], cache_p, dir_p, exp_valid, pad, exp_flit[15:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},  // 0  idle R8
    {4'b1101, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A0},  // 1  R2
    {4'b1101, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A2},  // 2  R2
    {4'b1101, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A3},  // 3  R2
    {4'b1101, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A0},  // 4  R2 wrap
    {4'b1101, 4'b0100, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00A3},  // 5  R1 stop
    {4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h00D0},  // 6  R6 R7
    {4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h00D0},  // 7  R4 hold
    {4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h00C0},  // 8  R5 release
    {4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h00C0},  // 9  R4 hold
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00D0},  // 10 R5
    {4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00A0},  // 11 R3
    {4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00D0},  // 12 R3
    {4'b0001, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 16'h00A0},  // 13 R1 resp stop
    {4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}   // 14 idle R8
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NV-1:0] vc_pending = '0, vc_stop = '0, vc_flit_valid = '1;
  logic [NV*FW-1:0] vc_flit;
  logic cache_pending = 1'b0, dir_pending = 1'b0;
  logic [FW-1:0] port_flit;
  logic port_flit_valid;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign vc_flit = {16'h00A3, 16'h00A2, 16'h00A1, 16'h00A0};

  vc_inject_arb #(.NUM_VC(NV), .FLIT_W(FW), .RESP_VC(1)) dut_i (
    .clk(clk), .rst(rst), .vc_pending(vc_pending), .vc_stop(vc_stop),
    .vc_flit(vc_flit), .vc_flit_valid(vc_flit_valid),
    .cache_pending(cache_pending), .cache_flit(16'h00C0), .cache_flit_valid(1'b1),
    .dir_pending(dir_pending), .dir_flit(16'h00D0), .dir_flit_valid(1'b1),
    .port_flit(port_flit), .port_flit_valid(port_flit_valid));

  function automatic string tag_of(input int i);
    case (i)
      0, 14:     return "R8";
      1, 2, 3, 4: return "R2";
      5, 13:     return "R1";
      6:         return "R6";
      7, 9:      return "R4";
      8, 10:     return "R5";
      default:   return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic v, input logic [FW-1:0] f,
                       input logic ev, input logic [FW-1:0] ef);
    checks++;
    if (v !== ev || f !== ef) begin
      errors++;
      $display("FAIL %s valid=%0b flit=%h expected valid=%0b flit=%h", tag, v, f, ev, ef);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R9", port_flit_valid, port_flit, 1'b0, 16'h0000);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      vc_pending    = VEC[i][27:24];
      vc_stop       = VEC[i][23:20];
      cache_pending = VEC[i][19];
      dir_pending   = VEC[i][18];
      @(posedge clk);
      #1 check(tag_of(i), port_flit_valid, port_flit, VEC[i][17], VEC[i][15:0]);
    end
    // R7: response channel wins alone when only its injectors are pending
    @(negedge clk); cache_pending = 1'b1;
    @(posedge clk); #1 check("R7", port_flit_valid, port_flit, 1'b1, 16'h00C0);
    // R10: channel 0 granted with its flit-valid low (port priority now at channel 2)
    @(negedge clk); cache_pending = 1'b0; vc_pending = 4'b0001; vc_flit_valid = 4'b1110;
    @(posedge clk); #1 check("R10", port_flit_valid, port_flit, 1'b0, 16'h00A0);
    @(negedge clk); vc_flit_valid = '1;
    @(posedge clk); #1 check("R3", port_flit_valid, port_flit, 1'b1, 16'h00A0);
    // R9: reset clears outputs while a channel is pending
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 check("R9", port_flit_valid, port_flit, 1'b0, 16'h0000);
    // R2: priority back to channel 0 after reset
    @(negedge clk); rst = 1'b0; vc_pending = 4'b1101;
    @(posedge clk); #1 check("R2", port_flit_valid, port_flit, 1'b1, 16'h00A0);
    // R5: directory side first after reset when both respond
    @(negedge clk); vc_pending = '0; cache_pending = 1'b1; dir_pending = 1'b1;
    @(posedge clk); #1 check("R5", port_flit_valid, port_flit, 1'b1, 16'h00D0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule